// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Controller

This block is the memory-side half of a small two-wire slave that fronts a 256-byte nonvolatile array. The protocol front end gives it already-decoded events: a START or STOP was seen, a memory-access or configuration command was just decoded, a data byte arrived, or the master wants a byte. The block keeps the address pointer and gathers write bytes into an 8-byte page buffer. On a STOP it copies the buffered bytes into the array. A repeated START drops them. After a commit it reports busy for a fixed number of system clocks. The front end uses this flag to withhold its acknowledge.

The nonvolatile array is modelled as a register array. Write bytes may only move within one 8-byte page. Reads walk the whole array, and the pointer wraps from the last byte back to the first. A one-byte configuration register shares the same commit, abort and busy rules. The busy duration is a parameter, so a short value can be used for simulation.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: After `mem_cmd_i` is pulsed in idle, the next `wr_valid_i` byte loads the address pointer, and `ptr_o` shows it one cycle later.
- R2: Each further write byte goes to page slot `ptr_o[2:0]`. Only those 3 low bits then increment (7 wraps to 0), and `ptr_o[7:3]` stays fixed. Bytes beyond 8 overwrite earlier slots: starting at 00h with bytes 00h,11h,...,99h, addresses 00h..07h end as 88h,99h,22h,33h,44h,55h,66h,77h.
- R3: `stop_i` after buffered bytes commits only the written slots, each to address {`ptr_o[7:3]`, slot}. The other bytes of that page keep their contents.
- R4: `start_i` while bytes or a configuration byte are buffered discards them. The array and `cfg_o` are unchanged, and `busy_o` stays 0.
- R5: A commit sets `busy_o` one cycle after `stop_i`, and it stays 1 for exactly BUSY_CYC cycles. `stop_i` with nothing buffered leaves `busy_o` at 0.
- R6: While `busy_o` is 1, every input event is ignored: `ptr_o`, `cfg_o` and the array do not change, and `rd_valid_o` stays 0.
- R7: `rd_req_i` (not busy, no write byte in the same cycle) returns the byte at `ptr_o` on `rd_data_o` with `rd_valid_o`=1 in the next cycle. It also increments the full 8-bit pointer, which wraps from FFh to 00h. Starting at 04h, 30 reads end at 21h with `ptr_o`=22h.
- R8: After `cfg_cmd_i`, a write byte is held and committed to `cfg_o` on `stop_i`. This runs the same busy period as R5.
- R9: After reset, `ptr_o`=0, `busy_o`=0, `rd_valid_o`=0, `cfg_o`=CFG_RST, and every array byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | START or repeated START seen (pulse) |
| stop_i | input | 1 | STOP seen (pulse) |
| mem_cmd_i | input | 1 | Memory-access command decoded (pulse) |
| cfg_cmd_i | input | 1 | Configuration-access command decoded (pulse) |
| wr_valid_i | input | 1 | Write byte received (pulse) |
| wr_data_i | input | 8 | Received write byte |
| rd_req_i | input | 1 | Master requests the next byte (pulse) |
| rd_data_o | output | 8 | Byte returned for a read |
| rd_valid_o | output | 1 | rd_data_o valid for one cycle |
| ptr_o | output | 8 | Current address pointer |
| cfg_o | output | 8 | Committed configuration byte |
| busy_o | output | 1 | Write cycle in progress; front end must not acknowledge |

## Verification
First, every page is written with bytes computed from their address, and the whole array is read back from 00h. This separates addressing and commit errors on all 256 locations, and it also exercises the pointer wrap at FFh. Several writes then tell apart the buffer behaviours: an overlong 10-byte burst shows slot overwrite, a 3-byte burst starting at 2Eh shows the wrap within the page and the preservation of unwritten bytes, and a burst ended by START shows abort. The busy window is measured cycle by cycle. Reads, commands and bytes are issued inside it to show that they are ignored. Configuration commit and abort are checked through `cfg_o`.

// File: rtl/eepc_pkg.sv
package eepc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_CFG  = 2'd3
  } st_e;
endpackage

// File: rtl/eepc_page_buf.sv
module eepc_page_buf #(
  parameter int DATA_W = 8,
  parameter int SLOT_W = 3,
  localparam int SLOTS = 1 << SLOT_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clr_i,
  input  logic                          wr_i,
  input  logic [SLOT_W-1:0]             idx_i,
  input  logic [DATA_W-1:0]             data_i,
  output logic [SLOTS-1:0][DATA_W-1:0]  data_o,
  output logic [SLOTS-1:0]              mask_o
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[s] <= '0;
        mask_o[s] <= 1'b0;
      end else if (clr_i) begin
        mask_o[s] <= 1'b0;
      end else if (wr_i && idx_i == SLOT_W'(s)) begin
        data_o[s] <= data_i;
        mask_o[s] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/eepc_nv_array.sv
module eepc_nv_array #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int SLOT_W = 3,
  localparam int WORDS  = 1 << ADDR_W,
  localparam int SLOTS  = 1 << SLOT_W,
  localparam int PAGE_W = ADDR_W - SLOT_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          commit_i,
  input  logic [PAGE_W-1:0]             page_i,
  input  logic [SLOTS-1:0][DATA_W-1:0]  buf_i,
  input  logic [SLOTS-1:0]              mask_i,
  input  logic [ADDR_W-1:0]             rd_addr_i,
  output logic [DATA_W-1:0]             rd_data_o
);
  logic [DATA_W-1:0] mem_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [ADDR_W-1:0] WA = ADDR_W'(w);
    logic we;
    assign we = commit_i && (page_i == WA[ADDR_W-1:SLOT_W]) && mask_i[WA[SLOT_W-1:0]];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  mem_q[w] <= '0;
      else if (we)  mem_q[w] <= buf_i[WA[SLOT_W-1:0]];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/eepc_busy_timer.sv
module eepc_busy_timer #(
  parameter int BUSY_CYC = 64,
  localparam int CNT_W = $clog2(BUSY_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (load_i)     cnt_q <= CNT_W'(BUSY_CYC);
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl #(
  parameter int               DATA_W   = 8,
  parameter int               ADDR_W   = 8,
  parameter int               SLOT_W   = 3,
  parameter int               BUSY_CYC = 64,
  parameter logic [DATA_W-1:0] CFG_RST = '0,
  localparam int SLOTS  = 1 << SLOT_W,
  localparam int PAGE_W = ADDR_W - SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              mem_cmd_i,
  input  logic              cfg_cmd_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_req_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic              busy_o
);
  import eepc_pkg::*;

  st_e                          st_q, st_d;
  logic [ADDR_W-1:0]            ptr_q, ptr_d;
  logic [DATA_W-1:0]            cfg_q, cfg_pend_q;
  logic                         cfg_have_q;
  logic [SLOTS-1:0][DATA_W-1:0] buf_data;
  logic [SLOTS-1:0]             buf_mask;
  logic [DATA_W-1:0]            arr_rd;
  logic                         live, buf_wr, buf_clr, mem_commit, cfg_commit, rd_go;

  assign live       = !busy_o;
  assign buf_wr     = live && !start_i && !stop_i && wr_valid_i && st_q == ST_DATA;
  assign mem_commit = live && !start_i && stop_i && st_q == ST_DATA && (|buf_mask);
  assign cfg_commit = live && !start_i && stop_i && st_q == ST_CFG && cfg_have_q;
  assign buf_clr    = live && (start_i || stop_i);
  assign rd_go      = live && rd_req_i && !wr_valid_i && !start_i && !stop_i;

  always_comb begin
    st_d  = st_q;
    ptr_d = ptr_q;
    if (live) begin
      if (start_i || stop_i) begin
        st_d = ST_IDLE;
      end else if (st_q == ST_IDLE && mem_cmd_i) begin
        st_d = ST_ADDR;
      end else if (st_q == ST_IDLE && cfg_cmd_i) begin
        st_d = ST_CFG;
      end else if (wr_valid_i) begin
        if (st_q == ST_ADDR) begin
          ptr_d = wr_data_i[ADDR_W-1:0];
          st_d  = ST_DATA;
        end else if (st_q == ST_DATA) begin
          ptr_d = {ptr_q[ADDR_W-1:SLOT_W], ptr_q[SLOT_W-1:0] + 1'b1};
        end
      end else if (rd_go) begin
        ptr_d = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      ptr_q      <= '0;
      cfg_q      <= CFG_RST;
      cfg_pend_q <= '0;
      cfg_have_q <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      st_q       <= st_d;
      ptr_q      <= ptr_d;
      rd_valid_o <= rd_go;
      if (rd_go) rd_data_o <= arr_rd;
      if (cfg_commit) cfg_q <= cfg_pend_q;
      if (buf_clr) begin
        cfg_have_q <= 1'b0;
      end else if (live && wr_valid_i && st_q == ST_CFG) begin
        cfg_pend_q <= wr_data_i;
        cfg_have_q <= 1'b1;
      end
    end
  end

  eepc_page_buf #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (buf_clr),
    .wr_i   (buf_wr),
    .idx_i  (ptr_q[SLOT_W-1:0]),
    .data_i (wr_data_i),
    .data_o (buf_data),
    .mask_o (buf_mask)
  );

  eepc_nv_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .commit_i  (mem_commit),
    .page_i    (ptr_q[ADDR_W-1:SLOT_W]),
    .buf_i     (buf_data),
    .mask_i    (buf_mask),
    .rd_addr_i (ptr_q),
    .rd_data_o (arr_rd)
  );

  eepc_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (mem_commit || cfg_commit),
    .busy_o (busy_o)
  );

  assign ptr_o = ptr_q;
  assign cfg_o = cfg_q;
endmodule

// File: rtl/eeprom_page_ctrl_chk.sv
module eeprom_page_ctrl_chk #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int SLOT_W   = 3,
  parameter int BUSY_CYC = 64,
  localparam int RUN_W = $clog2(BUSY_CYC + 2)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              stop_i,
  input logic              wr_valid_i,
  input logic              rd_req_i,
  input logic              rd_valid_o,
  input logic [ADDR_W-1:0] ptr_o,
  input logic [DATA_W-1:0] cfg_o,
  input logic              busy_o,
  input eepc_pkg::st_e     st_q
);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  AST_PAGE_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == eepc_pkg::ST_DATA && wr_valid_i && !busy_o && !start_i && !stop_i)
    |=> ptr_o == {$past(ptr_o[ADDR_W-1:SLOT_W]), $past(ptr_o[SLOT_W-1:0]) + SLOT_W'(1)}); // R2

  AST_BUSY_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i)); // R5

  AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_W'(BUSY_CYC)); // R5

  AST_BUSY_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(ptr_o)); // R6

  AST_BUSY_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(cfg_o)); // R6

  AST_BUSY_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !rd_valid_o); // R6

  AST_READ_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !busy_o && !wr_valid_i && !start_i && !stop_i)
    |=> (ptr_o == $past(ptr_o) + ADDR_W'(1)) && rd_valid_o); // R7

  AST_VALID_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_req_i)); // R7
endmodule

bind eeprom_page_ctrl eeprom_page_ctrl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .BUSY_CYC(BUSY_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .stop_i     (stop_i),
  .wr_valid_i (wr_valid_i),
  .rd_req_i   (rd_req_i),
  .rd_valid_o (rd_valid_o),
  .ptr_o      (ptr_o),
  .cfg_o      (cfg_o),
  .busy_o     (busy_o),
  .st_q       (st_q)
);

// File: tb/eeprom_page_ctrl_bench.sv
module eeprom_page_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY       = 20;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 0, stop_i = 0, mem_cmd_i = 0, cfg_cmd_i = 0;
  logic       wr_valid_i = 0, rd_req_i = 0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o, ptr_o, cfg_o;
  logic       rd_valid_o, busy_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [256];
  logic [7:0] wbuf  [16];

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  eeprom_page_ctrl #(.BUSY_CYC(BUSY), .CFG_RST(8'h00)) u_eeprom_page_ctrl (
    .clk_i, .rst_ni, .start_i, .stop_i, .mem_cmd_i, .cfg_cmd_i,
    .wr_valid_i, .wr_data_i, .rd_req_i, .rd_data_o, .rd_valid_o,
    .ptr_o, .cfg_o, .busy_o
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ev_start(); @(negedge clk_i); start_i = 1; @(negedge clk_i); start_i = 0; endtask
  task automatic ev_stop();  @(negedge clk_i); stop_i = 1;  @(negedge clk_i); stop_i = 0;  endtask
  task automatic ev_mem();   @(negedge clk_i); mem_cmd_i = 1; @(negedge clk_i); mem_cmd_i = 0; endtask
  task automatic ev_cfg();   @(negedge clk_i); cfg_cmd_i = 1; @(negedge clk_i); cfg_cmd_i = 0; endtask

  task automatic ev_wr(input logic [7:0] b);
    @(negedge clk_i); wr_valid_i = 1; wr_data_i = b;
    @(negedge clk_i); wr_valid_i = 0;
  endtask

  task automatic ev_rd(output logic [7:0] d, output logic v);
    @(negedge clk_i); rd_req_i = 1;
    @(negedge clk_i); rd_req_i = 0; d = rd_data_o; v = rd_valid_o;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk_i);
  endtask

  task automatic set_ptr(input logic [7:0] a);
    ev_mem(); ev_wr(a); ev_stop();
  endtask

  // write n bytes from wbuf at a, end with STOP, update model per slot rules
  task automatic page_write(input logic [7:0] a, input int n);
    ev_mem(); ev_wr(a);
    for (int i = 0; i < n; i++) begin
      ev_wr(wbuf[i]);
      model[{a[7:3], 3'(int'(a[2:0]) + i)}] = wbuf[i];
    end
    ev_stop();
  endtask

  task automatic read_cmp(input logic [7:0] a, input int n, input string req);
    logic [7:0] d;
    logic v;
    set_ptr(a);
    for (int i = 0; i < n; i++) begin
      ev_rd(d, v);
      check(v && d == model[8'(int'(a) + i)], req, {v, d}, {1'b1, model[8'(int'(a) + i)]});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic v;
    int n;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R9 reset state
    check(ptr_o == 0 && !busy_o && !rd_valid_o, "R9 ptr/busy/valid", {ptr_o, busy_o, rd_valid_o}, 0);
    check(cfg_o == 8'h00, "R9 cfg", cfg_o, 0);
    read_cmp(8'h00, 8, "R9 array zero");

    // R1 pointer load; R5 stop with nothing buffered
    ev_mem(); ev_wr(8'h90); ev_stop();
    check(ptr_o == 8'h90, "R1 ptr load", ptr_o, 8'h90);
    check(!busy_o, "R5 empty stop no busy", busy_o, 0);

    // R3 full sweep of every page with address-derived bytes
    for (int p = 0; p < 32; p++) begin
      for (int i = 0; i < 8; i++) wbuf[i] = pat(p * 8 + i);
      page_write(8'(p * 8), 8);
      wait_idle();
    end
    // R7 whole array read with wrap back to 00h
    read_cmp(8'h00, 256, "R3 R7 sweep");
    check(ptr_o == 8'h00, "R7 wrap FF->00", ptr_o, 0);

    // R2 overlong burst, R5 busy length
    for (int i = 0; i < 10; i++) wbuf[i] = 8'(i * 8'h11);
    page_write(8'h00, 10);
    n = 0;
    while (busy_o) begin n++; @(negedge clk_i); end
    check(n == BUSY, "R5 busy length", n, BUSY);
    check(model[0] == 8'h88 && model[1] == 8'h99 && model[2] == 8'h22, "R2 model", model[0], 8'h88);
    read_cmp(8'h00, 8, "R2 overwrite");

    // R3 partial write wrapping in page, neighbours kept
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    page_write(8'h2E, 3);
    check(ptr_o == 8'h29, "R2 low bits wrap", ptr_o, 8'h29);
    wait_idle();
    read_cmp(8'h28, 8, "R3 partial");

    // R4 abort by repeated START
    ev_mem(); ev_wr(8'h40);
    for (int i = 0; i < 5; i++) ev_wr(8'hE0 + 8'(i));
    ev_start();
    check(!busy_o, "R4 abort no busy", busy_o, 0);
    read_cmp(8'h40, 8, "R4 abort kept");

    // R6 everything ignored while busy
    wbuf[0] = 8'h77;
    page_write(8'h10, 1);
    check(busy_o, "R6 busy set", busy_o, 1);
    ev_rd(d, v);
    check(!v, "R6 read ignored", v, 0);
    check(ptr_o == 8'h11, "R6 ptr held", ptr_o, 8'h11);
    ev_mem(); ev_wr(8'h33); ev_wr(8'h55); ev_stop();
    check(ptr_o == 8'h11, "R6 cmd ignored", ptr_o, 8'h11);
    ev_cfg(); ev_wr(8'h5C); ev_stop();
    check(cfg_o == 8'h00, "R6 cfg ignored", cfg_o, 0);
    wait_idle();
    read_cmp(8'h10, 8, "R6 array");

    // R7 wrap read and 30-byte read from 04h
    read_cmp(8'hFC, 6, "R7 wrap read");
    check(ptr_o == 8'h02, "R7 wrap ptr", ptr_o, 8'h02);
    read_cmp(8'h04, 30, "R7 run");
    check(ptr_o == 8'h22, "R7 end ptr", ptr_o, 8'h22);

    // R8 configuration commit and abort
    ev_cfg(); ev_wr(8'h01); ev_stop();
    check(busy_o, "R8 cfg busy", busy_o, 1);
    n = 0;
    while (busy_o) begin n++; @(negedge clk_i); end
    check(n == BUSY, "R8 cfg busy length", n, BUSY);
    check(cfg_o == 8'h01, "R8 cfg commit", cfg_o, 8'h01);
    ev_cfg(); ev_wr(8'h00); ev_start();
    check(cfg_o == 8'h01 && !busy_o, "R8 R4 cfg abort", cfg_o, 8'h01);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule